// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets synchronous logic use an external asynchronous static RAM of 256K words by 8 bits. The host presents one request at a time: an address, write data and a read/write flag, qualified by a valid strobe. The controller accepts the request only while it signals ready. It then runs a complete memory cycle on the RAM pins and reports completion with a single-cycle done pulse. For reads, the returned byte appears on the read data output together with that pulse.

On the memory side the controller drives the address, an active-low and an active-high chip enable, active-low write and output strobes, and a split data bus with its own output enable. Every pulse width, access window and bus-release window is a whole number of clock cycles. Each is computed while the design elaborates, by rounding the nanosecond figure of the chosen speed grade (100 ns or 85 ns) up to clock periods. Between requests the RAM is deselected and rests in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_ni` is low, both enables are inactive (`mem_ce_n_o`=1, `mem_ce_o`=0), `mem_we_n_o`=1, `mem_oe_n_o`=1, `mem_dq_oe_o`=0, `rsp_done_o`=0 and `req_ready_o`=1.
- R2: Whenever `req_ready_o` is high, the controller is idle and the RAM is in standby: `mem_ce_n_o`=1, `mem_ce_o`=0, `mem_oe_n_o`=1, `mem_we_n_o`=1 and `mem_dq_oe_o`=0.
- R3: `mem_addr_o` changes only between two clock edges at both of which `mem_we_n_o` is high. It takes the request address at the accepting edge and holds it until the next accepted request.
- R4: `mem_we_n_o` is low only while both enables are active and `mem_dq_oe_o` is high. In a write it stays low for exactly WP cycles, and the RAM captures `mem_dq_o` when the strobe rises.
- R5: A write takes one setup cycle, WP strobe cycles and one recovery cycle, with the data held on the bus through the recovery cycle. `rsp_done_o` goes high WP+2 cycles after the accepting edge.
- R6: `mem_oe_n_o` is low only while the RAM is selected and `mem_we_n_o` is high. A read holds the output strobe low for RD cycles and samples `mem_dq_i` at the last of them. It then shows that byte on `rsp_rdata_o` with `rsp_done_o` high RD cycles after the accepting edge, and `rsp_rdata_o` holds until the next read.
- R7: `rsp_done_o` is high for exactly one cycle per request.
- R8: The controller never drives `mem_dq_o` while `mem_oe_n_o` is low. It also keeps the bus released for REL cycles after a read ends, so that it cannot overlap a RAM that is still turning its drivers off.
- R9: After a write, the RAM is deselected and `req_ready_o` is low for one turnaround cycle before the next access can be accepted.
- R10: Cycle counts are ceil(ns / CLK_PERIOD_NS). RD comes from the read cycle time. WP is the largest of the strobe width, the data setup time, and the write cycle time less two. REL comes from the larger output turn-off time. For 100 ns parts at 10 ns this gives RD=10, WP=8, REL=4; for 85 ns parts it gives RD=9, WP=7, REL=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Controller idle, request accepted at this edge if valid |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Last read byte |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_ce_n_o | output | 1 | RAM enable, active low |
| mem_ce_o | output | 1 | RAM enable, active high |
| mem_we_n_o | output | 1 | RAM write strobe, active low |
| mem_oe_n_o | output | 1 | RAM output strobe, active low |
| mem_dq_o | output | DATA_W | Data towards RAM |
| mem_dq_i | input | DATA_W | Data from RAM |
| mem_dq_oe_o | output | 1 | Drive enable for `mem_dq_o` |

## Verification
Some rules are checked by the assertions on every cycle:
- The address moves only while the write strobe is high on both sides of the edge.
- The write strobe falls only with both enables active and data on the bus.
- The output strobe never overlaps the write strobe or the controller's own drive.
- Done never lasts two cycles, and an idle controller always leaves the RAM deselected.

Other behaviour needs the bench's scenarios with a RAM model. The model returns a poison byte if a read is sampled early, and it reports drive overlap within the release window. These scenarios show the exact strobe widths and the done latencies for both speed grades, the data stored and returned across overwrites, and the turnaround cycle after writes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REL,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOV,
    ST_TURN
  } seq_state_e;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // grade-dependent nanosecond figures
  function automatic int unsigned t_cyc_ns(input int unsigned grade);
    return (grade == 85) ? 85 : 100;
  endfunction

  function automatic int unsigned t_wp_ns(input int unsigned grade);
    return (grade == 85) ? 40 : 50;
  endfunction

  function automatic int unsigned t_dsu_ns(input int unsigned grade);
    return (grade == 85) ? 35 : 40;
  endfunction

  function automatic int unsigned t_oe_ns(input int unsigned grade);
    return (grade == 85) ? 40 : 45;
  endfunction

  function automatic int unsigned t_hz_ns(input int unsigned grade);
    return (grade == 85) ? 35 : 40;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned RD_CYC  = 10,
  parameter int unsigned WP_CYC  = 8,
  parameter int unsigned REL_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             tmr_zero_i,
  output seq_state_e       nxt_state_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             done_o
);
  seq_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept_o = 1'b1;
        if (req_write_i) state_d = ST_WR_SETUP;
        else begin
          state_d    = ST_RD_ACC;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD_ACC: if (tmr_zero_i) begin
        state_d    = ST_RD_REL;
        capture_o  = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(REL_CYC - 1);
      end
      ST_RD_REL: if (tmr_zero_i) state_d = ST_IDLE;
      ST_WR_SETUP: begin
        state_d    = ST_WR_PULSE;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(WP_CYC - 1);
      end
      ST_WR_PULSE: if (tmr_zero_i) state_d = ST_WR_RECOV;
      ST_WR_RECOV: state_d = ST_TURN;
      ST_TURN:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= capture_o || (state_q == ST_WR_RECOV);
    end
  end

  assign nxt_state_o = state_d;
  assign ready_o     = (state_q == ST_IDLE);
  assign done_o      = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o); // R9
endmodule

// File: rtl/sram_pin_driver.sv
module sram_pin_driver
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        nxt_state_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);
  logic sel_d, we_d, oe_d, drv_d;

  // pins are registered from the next state so strobes never glitch
  always_comb begin
    sel_d = nxt_state_i inside {ST_RD_ACC, ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOV};
    we_d  = (nxt_state_i == ST_WR_PULSE);
    oe_d  = (nxt_state_i == ST_RD_ACC);
    drv_d = nxt_state_i inside {ST_WR_PULSE, ST_WR_RECOV};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ce_n_o  <= 1'b1;
      mem_ce_o    <= 1'b0;
      mem_we_n_o  <= 1'b1;
      mem_oe_n_o  <= 1'b1;
      mem_dq_oe_o <= 1'b0;
    end else begin
      mem_ce_n_o  <= !sel_d;
      mem_ce_o    <= sel_d;
      mem_we_n_o  <= !we_d;
      mem_oe_n_o  <= !oe_d;
      mem_dq_oe_o <= drv_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
      rdata_o    <= '0;
    end else begin
      if (accept_i) begin
        mem_addr_o <= req_addr_i;
        mem_dq_o   <= req_wdata_i;
      end
      if (capture_i) rdata_o <= mem_dq_i;
    end
  end

  AST_ADDR_MOVES_WE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_we_n_o && $past(mem_we_n_o))); // R3
  AST_WE_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_ce_n_o && mem_ce_o && mem_dq_oe_o)); // R4
  AST_OE_NEEDS_WE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_ce_n_o && mem_ce_o)); // R6
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o); // R8
  AST_DATA_HELD_AFTER_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (mem_dq_oe_o && $stable(mem_dq_o))); // R5
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SPEED_GRADE   = 100,
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int unsigned RD_CYC  = max2(max2(cdiv(t_cyc_ns(SPEED_GRADE), CLK_PERIOD_NS),
                                              cdiv(t_oe_ns(SPEED_GRADE), CLK_PERIOD_NS)), 1);
  localparam int unsigned WC_CYC  = cdiv(t_cyc_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int unsigned WP_CYC  = max2(max2(cdiv(t_wp_ns(SPEED_GRADE), CLK_PERIOD_NS),
                                              cdiv(t_dsu_ns(SPEED_GRADE), CLK_PERIOD_NS)),
                                         max2((WC_CYC > 2) ? WC_CYC - 2 : 1, 1));
  localparam int unsigned REL_CYC = max2(cdiv(t_hz_ns(SPEED_GRADE), CLK_PERIOD_NS), 1);
  localparam int unsigned CNT_MAX = max2(max2(RD_CYC, WP_CYC), REL_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e       nxt_state;
  logic             tmr_load, tmr_zero, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_seq_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REL_CYC (REL_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .tmr_zero_i  (tmr_zero),
    .nxt_state_o (nxt_state),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .accept_o    (accept),
    .capture_o   (capture),
    .ready_o     (req_ready_o),
    .done_o      (rsp_done_o)
  );

  sram_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nxt_state_i (nxt_state),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .rdata_o     (rsp_rdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_ce_o    (mem_ce_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

  AST_IDLE_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_n_o && !mem_ce_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o)); // R2
endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps

module sram_tb_model #(
  parameter int unsigned RD_OK  = 9,
  parameter int unsigned HZ_CYC = 4
) (
  input  logic        clk,
  input  logic [17:0] addr,
  input  logic        ce_n,
  input  logic        ce,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [7:0]  dq_w,
  input  logic        dq_oe,
  output logic [7:0]  dq_r,
  output int          last_pulse,
  output int          contention,
  output int          addr_viol
);
  logic [7:0]  mem [256];
  logic        we_prev = 1'b1;
  logic [17:0] addr_prev = '0;
  int          wlen = 0, rcnt = 0, hz = 0;
  logic        sel, rd;

  assign sel  = !ce_n && ce;
  assign rd   = sel && !oe_n && we_n;
  assign dq_r = rd ? ((rcnt >= int'(RD_OK)) ? mem[addr[7:0]] : 8'hEE) : 8'h00;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    last_pulse = 0; contention = 0; addr_viol = 0;
  end

  always @(posedge clk) begin
    we_prev   <= we_n;
    addr_prev <= addr;
    if (addr != addr_prev && (!we_n || !we_prev)) addr_viol <= addr_viol + 1;
    if (!we_n) wlen <= wlen + 1;
    if (we_n && !we_prev) begin
      if (sel && dq_oe) mem[addr[7:0]] <= dq_w;
      last_pulse <= wlen;
      wlen <= 0;
    end
    rcnt <= rd ? rcnt + 1 : 0;
    if (rd) hz <= HZ_CYC;
    else if (hz != 0) hz <= hz - 1;
    if (dq_oe && (rd || hz != 0)) contention <= contention + 1;
  end
endmodule

module sram_async_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = !clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;

  logic        rdy_a, done_a, ce_n_a, ce_a, we_n_a, oe_n_a, dqoe_a;
  logic [7:0]  rdata_a, dqo_a, dqi_a;
  logic [17:0] addr_a;
  logic        rdy_b, done_b, ce_n_b, ce_b, we_n_b, oe_n_b, dqoe_b;
  logic [7:0]  rdata_b, dqo_b, dqi_b;
  logic [17:0] addr_b;
  int          pulse_a, cont_a, viol_a, pulse_b, cont_b, viol_b;

  sram_async_ctrl #(.CLK_PERIOD_NS(10), .SPEED_GRADE(100)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(rdy_a),
    .rsp_done_o(done_a), .rsp_rdata_o(rdata_a), .mem_addr_o(addr_a),
    .mem_ce_n_o(ce_n_a), .mem_ce_o(ce_a), .mem_we_n_o(we_n_a), .mem_oe_n_o(oe_n_a),
    .mem_dq_o(dqo_a), .mem_dq_i(dqi_a), .mem_dq_oe_o(dqoe_a));

  sram_async_ctrl #(.CLK_PERIOD_NS(10), .SPEED_GRADE(85)) dut_fast_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(rdy_b),
    .rsp_done_o(done_b), .rsp_rdata_o(rdata_b), .mem_addr_o(addr_b),
    .mem_ce_n_o(ce_n_b), .mem_ce_o(ce_b), .mem_we_n_o(we_n_b), .mem_oe_n_o(oe_n_b),
    .mem_dq_o(dqo_b), .mem_dq_i(dqi_b), .mem_dq_oe_o(dqoe_b));

  // read valid only after ceil(t_rc/T) cycles: threshold is one less in model counts
  sram_tb_model #(.RD_OK(9), .HZ_CYC(4)) m_a (
    .clk(clk), .addr(addr_a), .ce_n(ce_n_a), .ce(ce_a), .we_n(we_n_a), .oe_n(oe_n_a),
    .dq_w(dqo_a), .dq_oe(dqoe_a), .dq_r(dqi_a), .last_pulse(pulse_a),
    .contention(cont_a), .addr_viol(viol_a));
  sram_tb_model #(.RD_OK(8), .HZ_CYC(4)) m_b (
    .clk(clk), .addr(addr_b), .ce_n(ce_n_b), .ce(ce_b), .we_n(we_n_b), .oe_n(oe_n_b),
    .dq_w(dqo_b), .dq_oe(dqoe_b), .dq_r(dqi_b), .last_pulse(pulse_b),
    .contention(cont_b), .addr_viol(viol_b));

  // expected counts per R10
  localparam int RD_A = 10, WP_A = 8, RD_B = 9, WP_B = 7;

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // {write, addr, data}
  localparam logic [26:0] VEC [10] = '{
    {1'b1, 18'h00011, 8'h5A},
    {1'b1, 18'h3FF22, 8'hC3},
    {1'b0, 18'h00011, 8'h5A},
    {1'b1, 18'h20033, 8'hFF},
    {1'b0, 18'h3FF22, 8'hC3},
    {1'b1, 18'h1FF44, 8'h00},
    {1'b1, 18'h00011, 8'hA5},
    {1'b0, 18'h00011, 8'hA5},
    {1'b0, 18'h20033, 8'hFF},
    {1'b0, 18'h00055, 8'h00}
  };

  task automatic do_req(input bit wr, input logic [17:0] a, input logic [7:0] d);
    int n = 0, na = 0, nb = 0;
    bit pa = 0, pb = 0;
    while (!(rdy_a && rdy_b)) @(negedge clk);
    check(ce_n_a && !ce_a && oe_n_a && we_n_a && !dqoe_a, "R2 idle standby", ce_n_a, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (n < 60) begin
      @(posedge clk); n++;
      @(negedge clk);
      req_valid = 1'b0;
      if (na != 0 && !pa) begin
        pa = 1; check(!done_a, "R7 done single cycle", done_a, 0);
      end
      if (nb != 0 && !pb) begin
        pb = 1; check(!done_b, "R7 done single cycle fast", done_b, 0);
      end
      if (done_a && na == 0) begin
        na = n;
        if (wr) begin
          check(na == WP_A + 3, "R5 write done latency", na - 1, WP_A + 2);
          check(pulse_a == WP_A, "R4 write strobe width", pulse_a, WP_A);
          check(ce_n_a && !ce_a && !rdy_a, "R9 turnaround deselect", {ce_n_a, rdy_a}, 2'b10);
        end else begin
          check(na == RD_A + 1, "R6 read done latency", na - 1, RD_A);
          check(rdata_a == d, "R6 read data", rdata_a, d);
        end
        check(addr_a == a, "R3 address held", addr_a, a);
      end
      if (done_b && nb == 0) begin
        nb = n;
        if (wr) begin
          check(nb == WP_B + 3, "R10 fast write latency", nb - 1, WP_B + 2);
          check(pulse_b == WP_B, "R10 fast strobe width", pulse_b, WP_B);
        end else begin
          check(nb == RD_B + 1, "R10 fast read latency", nb - 1, RD_B);
          check(rdata_b == d, "R10 fast read data", rdata_b, d);
        end
      end
      if (pa && pb) break;
    end
    if (!(pa && pb)) begin
      check(1'b0, "watchdog request hung", n, 0);
      finish_run();
    end
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog global", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ce_n_a && !ce_a && we_n_a && oe_n_a && !dqoe_a && !done_a && rdy_a,
          "R1 reset pins", {ce_n_a, ce_a, we_n_a, oe_n_a, dqoe_a, done_a, rdy_a}, 7'b1011001);
    rst_ni = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) do_req(VEC[i][26], VEC[i][25:8], VEC[i][7:0]);

    // R6: read data holds after a following write
    do_req(1'b1, 18'h00077, 8'h3C);
    check(rdata_a == 8'h00, "R6 rdata held across write", rdata_a, 0);
    // R9: read right after the write sees the new byte, not poison
    do_req(1'b0, 18'h00077, 8'h3C);
    // R8 / R3 monitor totals
    check(cont_a == 0 && cont_b == 0, "R8 no bus overlap", cont_a + cont_b, 0);
    check(viol_a == 0 && viol_b == 0, "R3 address moved with strobe low", viol_a + viol_b, 0);

    // mid-cycle reset returns pins to standby (R1)
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00088; req_wdata = 8'h11;
    @(negedge clk); req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(ce_n_a && we_n_a && !dqoe_a && rdy_a, "R1 reset mid write", {ce_n_a, we_n_a, dqoe_a}, 3'b110);
    rst_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule